// File: doc/BRIEF.md
# Intra Block Edge Overlap Smoother

This block smooths the seams between neighbouring intra-coded 8x8 blocks of a reconstructed picture. It runs after the inverse transform has rebuilt the blocks and before any deblocking. Its input is the unclamped signed 10-bit reconstruction, streamed in one sample per cycle. The block works on a 16x16 tile made of four 8x8 blocks. Numbered in raster order, they are 0 (top left), 1 (top right), 2 (bottom left) and 3 (bottom right).

Once the tile is loaded, the block smooths the inner vertical seam, one row per cycle. It then smooths the inner horizontal seam, one column per cycle, unless the picture is an interlaced frame. Each seam crossing touches four pixels: the two on each side of the boundary. After the passes, every pixel gets a bias of 128 and is clamped to 8 bits. The result is streamed out in raster order. A seam is smoothed only when both blocks it separates are intra coded and smoothing is switched on. When conditional smoothing is selected, both blocks must also carry their own smoothing flag.

Top module: `vc1_overlap_smooth`

## Requirements
- R1: Input loading.
  - While `ready` is high, each cycle with `in_valid` high stores one sample.
  - The 256 samples fill the tile row by row, left to right.
  - The configuration inputs are captured in the cycle of the 256th sample.
- R2: A seam is smoothed only when both adjoining blocks have their `blk_intra` bit set.
  - The vertical seam pairs blocks 0/1 for rows 0-7 and blocks 2/3 for rows 8-15.
  - The horizontal seam pairs blocks 0/2 for columns 0-7 and blocks 1/3 for columns 8-15.
  - All pixels that are not smoothed reach the output with only the bias and clamp applied.
- R3: Vertical seam filter.
  - For each row, x0..x3 are columns 6..9.
  - The outputs are:
    - y0=(7x0+x3+4)>>3
    - y1=(-x0+7x1+x2+x3+3)>>3
    - y2=(x0+x1+7x2-x3+4)>>3
    - y3=(x0+7x3+3)>>3
  - The shift is arithmetic.
- R4: Horizontal seam filter.
  - For progressive (`pic_struct`=0) and field (`pic_struct`=1) pictures, the horizontal seam is smoothed after the vertical one, on the vertically smoothed values.
  - For each column, x0..x3 are rows 6..9.
  - It uses the same matrix as R3, with rounding terms 3,4,3,4.
- R5: Interlaced frames (`pic_struct`=2) get only the vertical seam; the horizontal seam is left untouched.
- R6: With `cond_ovl`=1, a seam is smoothed only if both adjoining blocks also have their `blk_ovl` bit set.
- R7: With `ovl_en`=0, no seam is smoothed and the output is only the biased, clamped input.
- R8: Output stream.
  - Each output pixel is the stored value plus 128, clamped to 0..255.
  - 256 pixels stream out in raster order, one per cycle, with `out_valid` high.
  - `out_last` marks the 256th pixel.
  - `ready` stays low from the last input sample until the stream ends.
- R9: Output timing.
  - The first output pixel is valid 32 cycles after the clock edge that takes the last input sample.
  - For interlaced frames this is 16 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_pix | input | 10 | Signed reconstructed sample |
| blk_intra | input | 4 | Intra flag per block |
| blk_ovl | input | 4 | Per-block smoothing flag for conditional mode |
| ovl_en | input | 1 | Smoothing enable |
| cond_ovl | input | 1 | Conditional smoothing select |
| pic_struct | input | 2 | 0 progressive, 1 field, 2 interlaced frame |
| ready | output | 1 | Block accepts input samples |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 8 | Biased, clamped pixel |
| out_last | output | 1 | Final pixel of the tile |

## Verification
The vertical pass takes 16 cycles. The horizontal pass takes another 16 cycles, or none for interlaced frames. So the first output is due 32, or 16, cycles after the edge that takes the last input. After that, one pixel follows every cycle. The bench drives inputs on the falling edge. It counts rising edges from the one that takes the last sample to the first sample with `out_valid` high, and checks that count against 32 or 16. It then samples exactly one pixel one time unit after each following rising edge, so each comparison lines up with the pixel index the model predicts.

// File: rtl/vc1_overlap_smooth.sv
module vc1_overlap_smooth #(
  parameter int IN_W = 10,
  parameter int BLK  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_pix,
  input  logic [3:0]      blk_intra,
  input  logic [3:0]      blk_ovl,
  input  logic            ovl_en,
  input  logic            cond_ovl,
  input  logic [1:0]      pic_struct,
  output logic            ready,
  output logic            out_valid,
  output logic [7:0]      out_pix,
  output logic            out_last
);
  localparam int SIDE = 2 * BLK;
  localparam int NPIX = SIDE * SIDE;
  localparam int BW   = IN_W + 2;
  localparam int CW   = $clog2(NPIX);
  localparam int RW   = $clog2(SIDE);

  typedef enum logic [1:0] {S_LOAD, S_VERT, S_HORZ, S_OUT} state_t;
  state_t state;
  logic [CW-1:0] cnt;
  logic [3:0] intra_q, ovl_q;
  logic en_q, cond_q, ilace_q;

  logic signed [BW-1:0] pix [NPIX];

  logic [RW-1:0] line;
  logic [1:0] ba, bb;
  logic edge_on, vert;
  logic [CW-1:0] idx [4];
  logic signed [15:0] x [4];
  logic signed [15:0] t [4];
  logic signed [15:0] ra, rb;

  assign line = cnt[RW-1:0];
  assign vert = (state == S_VERT);

  always_comb begin
    if (vert) begin
      ba = line[RW-1] ? 2'd2 : 2'd0;
      bb = line[RW-1] ? 2'd3 : 2'd1;
    end else begin
      ba = line[RW-1] ? 2'd1 : 2'd0;
      bb = line[RW-1] ? 2'd3 : 2'd2;
    end
    for (int k = 0; k < 4; k++) begin
      if (vert) idx[k] = CW'(int'(line) * SIDE + BLK - 2 + k);
      else      idx[k] = CW'((BLK - 2 + k) * SIDE + int'(line));
      x[k] = 16'(pix[idx[k]]);
    end
    ra = vert ? 16'sd4 : 16'sd3;
    rb = vert ? 16'sd3 : 16'sd4;
    t[0] = (16'sd7 * x[0] + x[3] + ra) >>> 3;
    t[1] = (-x[0] + 16'sd7 * x[1] + x[2] + x[3] + rb) >>> 3;
    t[2] = (x[0] + x[1] + 16'sd7 * x[2] - x[3] + ra) >>> 3;
    t[3] = (x[0] + 16'sd7 * x[3] + rb) >>> 3;
  end

  assign edge_on = (state == S_VERT || state == S_HORZ) && en_q &&
                   intra_q[ba] && intra_q[bb] &&
                   (!cond_q || (ovl_q[ba] && ovl_q[bb]));

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid)
      pix[cnt] <= {{2{in_pix[IN_W-1]}}, in_pix};
    else if (edge_on)
      for (int k = 0; k < 4; k++) pix[idx[k]] <= t[k][BW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_LOAD;
      cnt     <= '0;
      intra_q <= '0;
      ovl_q   <= '0;
      en_q    <= 1'b0;
      cond_q  <= 1'b0;
      ilace_q <= 1'b0;
    end else begin
      case (state)
        S_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NPIX - 1)) begin
            intra_q <= blk_intra;
            ovl_q   <= blk_ovl;
            en_q    <= ovl_en;
            cond_q  <= cond_ovl;
            ilace_q <= (pic_struct == 2'd2);
            state   <= S_VERT;
          end
        end
        S_VERT: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SIDE - 1)) begin
            cnt   <= '0;
            state <= ilace_q ? S_OUT : S_HORZ;
          end
        end
        S_HORZ: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(SIDE - 1)) begin
            cnt   <= '0;
            state <= S_OUT;
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(NPIX - 1)) state <= S_LOAD;
        end
      endcase
    end
  end

  logic signed [BW:0] biased;
  assign biased    = BW'(pix[cnt]) + (BW+1)'(128);
  assign out_pix   = biased < 0 ? 8'd0 : (biased > 255 ? 8'd255 : biased[7:0]);
  assign out_valid = (state == S_OUT);
  assign out_last  = out_valid && (cnt == CW'(NPIX - 1));
  assign ready     = (state == S_LOAD);

  assert_ready_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(in_valid));
  assert_corner_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_LOAD) |=> $stable(pix[0]));
  assert_no_horz_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_VERT && ilace_q && cnt == CW'(SIDE - 1)) |=> out_valid);
  assert_stream_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (!out_valid && ready));
endmodule

// File: tb/vc1_overlap_smooth_test.sv
module vc1_overlap_smooth_test;
  logic clk = 0, rst_n = 0, in_valid = 0, ovl_en = 0, cond_ovl = 0;
  logic [9:0] in_pix = '0;
  logic [3:0] blk_intra = '0, blk_ovl = '0;
  logic [1:0] pic_struct = '0;
  logic ready, out_valid, out_last;
  logic [7:0] out_pix;

  vc1_overlap_smooth uut (.*);

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int src [256];
  int m [256];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit eok(int a, int b, logic [3:0] it, logic [3:0] ov, bit en, bit cd);
    return en && it[a] && it[b] && (!cd || (ov[a] && ov[b]));
  endfunction

  task automatic filt(int i0, int stride, int r0, int r1);
    int x0 = m[i0], x1 = m[i0+stride], x2 = m[i0+2*stride], x3 = m[i0+3*stride];
    m[i0]          = (7*x0 + x3 + r0) >>> 3;
    m[i0+stride]   = (-x0 + 7*x1 + x2 + x3 + r1) >>> 3;
    m[i0+2*stride] = (x0 + x1 + 7*x2 - x3 + r0) >>> 3;
    m[i0+3*stride] = (x0 + 7*x3 + r1) >>> 3;
  endtask

  task automatic run(string req, logic [3:0] it, logic [3:0] ov, bit en, bit cd, logic [1:0] ps);
    int lat = 0, bad = -1, bad_a = 0, bad_e = 0;
    for (int i = 0; i < 256; i++) m[i] = src[i];
    for (int r = 0; r < 16; r++)
      if (eok(r < 8 ? 0 : 2, r < 8 ? 1 : 3, it, ov, en, cd)) filt(r*16 + 6, 1, 4, 3);
    if (ps != 2)
      for (int c = 0; c < 16; c++)
        if (eok(c < 8 ? 0 : 1, c < 8 ? 2 : 3, it, ov, en, cd)) filt(6*16 + c, 16, 3, 4);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      in_valid = 1; in_pix = src[i][9:0];
      if (i == 255) begin
        blk_intra = it; blk_ovl = ov; ovl_en = en; cond_ovl = cd; pic_struct = ps;
      end else begin
        blk_intra = ~it; blk_ovl = ~ov; ovl_en = ~en; cond_ovl = ~cd; pic_struct = 2'd3 - ps;
      end
    end
    @(negedge clk); in_valid = 0;
    #1 check(!ready, "R8 ready low", ready, 0);
    while (!out_valid && lat < 100) begin
      @(posedge clk); #1 lat++;
    end
    check(lat == (ps == 2 ? 16 : 32), {req, " R9 latency"}, lat, ps == 2 ? 16 : 32);
    for (int i = 0; i < 256; i++) begin
      int e = m[i] + 128;
      if (e < 0) e = 0;
      if (e > 255) e = 255;
      if (bad < 0 && (!out_valid || out_pix != e[7:0] || out_last != (i == 255))) begin
        bad = i; bad_a = out_pix; bad_e = e;
      end
      @(posedge clk); #1;
    end
    check(bad < 0, {req, " R8 pixels"}, bad_a, bad_e);
    check(!out_valid && ready, "R8 stream end", out_valid, 0);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < 256; i++) src[i] = int'($urandom_range(1023)) - 512;
  endtask

  initial begin
    void'($urandom(32'd11));
    repeat (3) @(negedge clk);
    #1 check(ready && !out_valid && !out_last, "R1 reset state", ready, 1);
    rst_n = 1;
    fill_rand(); run("R1 R3 R4 progressive", 4'hF, 4'h0, 1, 0, 2'd0);
    fill_rand(); run("R4 field", 4'hF, 4'h0, 1, 0, 2'd1);
    fill_rand(); run("R5 interlaced", 4'hF, 4'h0, 1, 0, 2'd2);
    fill_rand(); run("R7 disabled", 4'hF, 4'hF, 0, 0, 2'd0);
    fill_rand(); run("R6 conditional", 4'hF, 4'b0111, 1, 1, 2'd0);
    fill_rand(); run("R2 mixed intra", 4'b1011, 4'h0, 1, 0, 2'd0);
    for (int i = 0; i < 256; i++) src[i] = ((i + i / 16) % 2) ? 511 : -512;
    run("R8 R3 extremes", 4'hF, 4'h0, 1, 0, 2'd0);
    for (int i = 0; i < 256; i++) src[i] = (i % 3 == 0) ? 127 : -129;
    run("R8 clamp edges", 4'h0, 4'h0, 1, 0, 2'd0);
    for (int n = 0; n < 4; n++) begin
      fill_rand();
      run("R2 R6 random", 4'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom_range(2)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule